// File: doc/BRIEF.md
# Video Format Auto-Detector

This block decides the operating format of a video encoder from sync timing that a separate sync tracker has already measured. The tracker sends a strobe with the pixel count of each completed line. It sends a second strobe at each field start, with the line count of the field that has just ended and the identifier of the field that is starting. From these inputs the block derives three mode flags. The first selects 625-line or 525-line operation. The second selects interlaced or non-interlaced scanning. The third selects square-pixel or 13.5 MHz sampling.

Detected flags are committed only at a field start, so the encoder never changes format in the middle of a field. A one-cycle pulse marks each committed change. When the force input is high, the flags and the setup-disable output come straight from the programmed bits and detection is bypassed. Detection keeps running in the background while force is high.

Top module: `fmt_detect`

## Requirements
- R1: After reset, is_625_o, nonintl_o, square_o, setup_dis_o and mode_chg_o are all 0, which means 525-line, interlaced, 13.5 MHz sampling and no change.
- R2: While force_i is 1, is_625_o, nonintl_o, square_o and setup_dis_o equal force_625_i, force_nonintl_i, force_square_i and force_setup_dis_i in the same cycle.
- R3: At every field start except the first one after reset, the detected line standard becomes 625-line when field_lines_i > 290 and 525-line otherwise.
- R4: At every field start except the first one after reset, non-interlaced is detected when field_id_i equals the field_id_i of the previous field start, and interlaced otherwise. Encoding: 0 means field 1 and 1 means field 2.
- R5: At a field start, square-pixel is detected only when the most recent line_px_i strobed since reset lies within ±1 of the square-pixel total. The total is 780 for 525-line and 944 for 625-line.
- R6: Each line is matched against the total for the line standard that is committed when that line is strobed. A switch to 625-line therefore shows square-pixel only at the field start after the first 625-line field.
- R7: Detected flags change only on the clock edge that samples field_start_i and are visible from the next cycle onward.
- R8: mode_chg_o is high for exactly the one cycle after a field start that changes any detected flag, and is low at all other times.
- R9: The first field start after reset changes no flag and raises no mode_chg_o, whatever field_lines_i is.
- R10: While force_i is 0, setup_dis_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_vld_i | input | 1 | One-cycle strobe: line_px_i holds a completed line's pixel count |
| line_px_i | input | 12 | Pixels counted between two horizontal sync falling edges |
| field_start_i | input | 1 | One-cycle strobe at each field start |
| field_lines_i | input | 10 | Lines counted in the field that just ended |
| field_id_i | input | 1 | Identifier of the starting field (0 = field 1, 1 = field 2) |
| force_i | input | 1 | 1 selects the programmed bits instead of detection |
| force_625_i | input | 1 | Programmed line standard (1 = 625-line) |
| force_nonintl_i | input | 1 | Programmed non-interlaced bit |
| force_square_i | input | 1 | Programmed square-pixel bit |
| force_setup_dis_i | input | 1 | Programmed setup-disable bit |
| is_625_o | output | 1 | 1 = 625-line, 0 = 525-line |
| nonintl_o | output | 1 | 1 = non-interlaced |
| square_o | output | 1 | 1 = square-pixel sampling, 0 = 13.5 MHz |
| setup_dis_o | output | 1 | Setup disable |
| mode_chg_o | output | 1 | One-cycle pulse when detected flags change |

## Verification
A wrong detection register shows up as a wrong flag in the cycle after the next field start. A stuck previous-parity or first-field bit shows up as a spurious non-interlaced flag or a spurious mode_chg_o pulse on the second field. A matcher that uses the wrong total or the wrong window misreports square-pixel within one field. The sweeps therefore place pixel counts just inside and just outside the window for both standards, and cross standards to expose the one-field lag.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef struct packed {
    logic is_625;
    logic nonintl;
    logic square;
  } fmt_t;
endpackage

// File: rtl/fmt_px_match.sv
module fmt_px_match #(
  parameter int PX_W   = 12,
  parameter int SQ_525 = 780,
  parameter int SQ_625 = 944,
  parameter int TOL    = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic [PX_W-1:0] px_i,
  input  logic            std_625_i,
  output logic            hit_o
);
  localparam int LO_525 = SQ_525 - TOL;
  localparam int HI_525 = SQ_525 + TOL;
  localparam int LO_625 = SQ_625 - TOL;
  localparam int HI_625 = SQ_625 + TOL;

  logic [PX_W-1:0] lo, hi;
  logic            in_win;
  logic            hit_q;

  assign lo     = std_625_i ? PX_W'(LO_625) : PX_W'(LO_525);
  assign hi     = std_625_i ? PX_W'(HI_625) : PX_W'(HI_525);
  assign in_win = (px_i >= lo) && (px_i <= hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hit_q <= 1'b0;
    else if (vld_i) hit_q <= in_win;
  end

  assign hit_o = hit_q;

  AST_SQ_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && !std_625_i && (px_i > PX_W'(HI_525) || px_i < PX_W'(LO_525)) |=> !hit_o); // R5
  AST_SQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(hit_o)); // R5
endmodule

// File: rtl/fmt_field_seq.sv
module fmt_field_seq #(
  parameter int LN_W    = 10,
  parameter int MIN_625 = 291
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [LN_W-1:0] lines_i,
  input  logic            id_i,
  output logic            upd_o,
  output logic            new_625_o,
  output logic            new_ni_o
);
  logic seen_q, prev_id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q    <= 1'b0;
      prev_id_q <= 1'b0;
    end else if (start_i) begin
      seen_q    <= 1'b1;
      prev_id_q <= id_i;
    end
  end

  // first start only arms the tracker
  assign upd_o     = start_i && seen_q;
  assign new_625_o = lines_i >= LN_W'(MIN_625);
  assign new_ni_o  = id_i == prev_id_q;

  AST_NO_UPD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!seen_q) && !seen_q |-> !upd_o); // R9
endmodule

// File: rtl/fmt_detect.sv
module fmt_detect #(
  parameter int PX_W    = 12,
  parameter int LN_W    = 10,
  parameter int SQ_525  = 780,
  parameter int SQ_625  = 944,
  parameter int PX_TOL  = 1,
  parameter int MIN_625 = 291
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            line_vld_i,
  input  logic [PX_W-1:0] line_px_i,
  input  logic            field_start_i,
  input  logic [LN_W-1:0] field_lines_i,
  input  logic            field_id_i,
  input  logic            force_i,
  input  logic            force_625_i,
  input  logic            force_nonintl_i,
  input  logic            force_square_i,
  input  logic            force_setup_dis_i,
  output logic            is_625_o,
  output logic            nonintl_o,
  output logic            square_o,
  output logic            setup_dis_o,
  output logic            mode_chg_o
);
  import fmt_pkg::*;

  fmt_t det_q, det_nxt;
  logic chg_q;
  logic upd, new_625, new_ni, sq_hit;

  fmt_px_match #(.PX_W(PX_W), .SQ_525(SQ_525), .SQ_625(SQ_625), .TOL(PX_TOL)) u_px (
    .clk_i, .rst_ni,
    .vld_i(line_vld_i), .px_i(line_px_i), .std_625_i(det_q.is_625), .hit_o(sq_hit)
  );

  fmt_field_seq #(.LN_W(LN_W), .MIN_625(MIN_625)) u_seq (
    .clk_i, .rst_ni,
    .start_i(field_start_i), .lines_i(field_lines_i), .id_i(field_id_i),
    .upd_o(upd), .new_625_o(new_625), .new_ni_o(new_ni)
  );

  always_comb begin
    det_nxt.is_625  = new_625;
    det_nxt.nonintl = new_ni;
    det_nxt.square  = sq_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q <= '0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= upd && (det_nxt != det_q);
      if (upd) det_q <= det_nxt;
    end
  end

  assign is_625_o    = force_i ? force_625_i       : det_q.is_625;
  assign nonintl_o   = force_i ? force_nonintl_i   : det_q.nonintl;
  assign square_o    = force_i ? force_square_i    : det_q.square;
  assign setup_dis_o = force_i ? force_setup_dis_i : 1'b0;
  assign mode_chg_o  = chg_q;

  AST_HOLD_OFF_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_start_i |=> $stable(det_q)); // R7
  AST_CHG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> $past(field_start_i)); // R8
  AST_CHG_REAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |-> !$stable(det_q)); // R8
  AST_625_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd && field_lines_i >= LN_W'(MIN_625) |=> det_q.is_625); // R3
endmodule

// File: tb/fmt_detect_tb.sv
module fmt_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_vld = 1'b0, field_start = 1'b0, field_id = 1'b0;
  logic [11:0] line_px = '0;
  logic [9:0] field_lines = '0;
  logic frc = 1'b0, f625 = 1'b0, fni = 1'b0, fsq = 1'b0, fsd = 1'b0;
  logic is_625, nonintl, square, setup_dis, mode_chg;
  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  bit m625 = 0, mni = 0, msq = 0, mseen = 0, mprev = 0, mhit = 0;

  always #2.5 clk = ~clk;

  fmt_detect u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .line_vld_i(line_vld), .line_px_i(line_px),
    .field_start_i(field_start), .field_lines_i(field_lines), .field_id_i(field_id),
    .force_i(frc), .force_625_i(f625), .force_nonintl_i(fni),
    .force_square_i(fsq), .force_setup_dis_i(fsd),
    .is_625_o(is_625), .nonintl_o(nonintl), .square_o(square),
    .setup_dis_o(setup_dis), .mode_chg_o(mode_chg)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(string req);
    chk(req, {is_625, nonintl, square}, {m625, mni, msq});
  endtask

  task automatic send_line(int px);
    int tot;
    tot = m625 ? 944 : 780;
    mhit = (px >= tot - 1) && (px <= tot + 1);
    line_vld = 1'b1; line_px = 12'(px);
    @(posedge clk); @(negedge clk);
    line_vld = 1'b0;
  endtask

  task automatic send_field(int lines, bit id, string req);
    bit chg;
    bit n625, nni;
    chg = 0;
    if (mseen) begin
      n625 = lines > 290;
      nni = (id == mprev);
      chg = (n625 != m625) || (nni != mni) || (mhit != msq);
      m625 = n625; mni = nni; msq = mhit;
    end
    mseen = 1; mprev = id;
    field_start = 1'b1; field_lines = 10'(lines); field_id = id;
    @(posedge clk); @(negedge clk);
    field_start = 1'b0;
    chk_flags(req);
    chk({req, " R8"}, mode_chg, chg);
    @(posedge clk); @(negedge clk);
    chk("R8", mode_chg, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    done = 1;
  end

  initial begin
    bit id;
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk_flags("R1");
    chk("R1", setup_dis, 0);
    chk("R1", mode_chg, 0);
    // first start ignores line count
    send_line(780);
    send_field(312, 1'b0, "R9");
    // R5 sweep around 525 total
    id = 1'b1;
    for (int px = 775; px <= 785; px++) begin
      send_line(px);
      send_field(262 + (px & 1), id, "R5");
      id = ~id;
    end
    // R3 line count boundary
    for (int ln = 288; ln <= 293; ln++) begin
      send_field(ln, id, "R3");
      id = ~id;
    end
    // R5 sweep around 625 total (standard now 625)
    for (int px = 939; px <= 949; px++) begin
      send_line(px);
      send_field(312 + (px & 1), id, "R5");
      id = ~id;
    end
    // R6 lag when crossing standards
    send_line(780); send_field(262, id, "R6"); id = ~id;
    send_line(944); send_field(312, id, "R6"); id = ~id;
    send_line(944); send_field(312, id, "R6"); id = ~id;
    // R4 parity repetition
    send_field(312, id, "R4");
    send_field(312, id, "R4");
    send_field(312, ~id, "R4");
    send_field(312, ~id, "R4");
    send_field(312, id, "R4");
    // R7 no change without a start
    send_line(700);
    repeat (3) @(negedge clk);
    chk_flags("R7");
    // R2 exhaustive force bits, R10 after
    for (int v = 0; v < 16; v++) begin
      frc = 1'b1;
      {f625, fni, fsq, fsd} = 4'(v);
      @(negedge clk);
      chk("R2", {is_625, nonintl, square, setup_dis}, v);
    end
    frc = 1'b0;
    @(negedge clk);
    chk_flags("R10");
    chk("R10", setup_dis, 0);
    done = 1;
  end

  initial begin
    wait (done);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule